// File: doc/BRIEF.md
# Flash Byte-Program Sequencer

This block programs a single byte into a parallel NOR-style flash device and tells the host whether the write succeeded. The host gives a one-cycle start pulse together with a target address and a data byte. The sequencer then drives a simple synchronous memory bus through the command cycles that unlock the device and program the byte. After that it polls the device status until the write finishes or the device reports a fault.

Completion is judged only on bit 7 of a status read: while the device is busy, that bit reads as the inverse of bit 7 of the byte being written. The error flag in bit 5 is not trusted on its own. When it is set, one more read decides, because the device may have finished between the two reads. A confirmed error, or a host-side watchdog expiring, ends with a reset command that puts the device back into read mode. The byte read back after completion is taken on a separate, later access, since the first read that shows a bit-7 match may carry unsettled low bits.

Top module: `flash_byte_prog`

## Requirements
- R1: After reset the bus strobes, `done_o`, `fail_o` and `rdata_o` are all low.
- R2: After a start, the first two accesses are writes: 0xAA to address 0xAAA, and then 0x55 to address 0x555.
- R3: The third access writes 0xA0 to address 0xAAA. The fourth writes the data byte to the target address.
- R4: The sequencer then reads the target address repeatedly. A read whose bit 7 equals bit 7 of the data byte counts as completion.
- R5: A poll read with bit 7 mismatched and bit 5 set is followed by exactly one confirming read. If bit 7 matches in that confirming read, the write counts as a success.
- R6: If the confirming read still shows a bit-7 mismatch, the sequencer writes 0xF0 to address 0x0000 and then reports failure.
- R7: On success, one extra read of the target follows the completing read. `rdata_o` holds the value from that extra read.
- R8: `done_o` is a single-cycle pulse two cycles after the strobe of the last access. `fail_o` is high only together with `done_o`.
- R9: A start pulse is ignored while an operation is in progress. The bus sequence and the result of that operation are unchanged.
- R10: A poll read that shows neither a bit-7 match nor bit 5 ends the operation through the R6 reset write and failure when the watchdog limit is reached. The count runs from the first poll strobe; poll n is sampled when the count reaches 2n+1 (n counted from 0). The limit is `WDOG_LIMIT` cycles.
- R11: Each access is one cycle with exactly one strobe high, followed by one cycle with no strobe. The data for a read is sampled in that second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to program a byte |
| addr_i | input | AW | Target address, captured at start |
| data_i | input | 8 | Byte to program, captured at start |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | 8 | Read data, valid the cycle after the read strobe |
| done_o | output | 1 | Completion pulse |
| fail_o | output | 1 | Failure flag, valid with done_o |
| rdata_o | output | 8 | Byte read back after a successful write |

## Verification
The bench targets five cases: a byte that is already written on the first poll, a byte that stays busy for several polls, and bit 5 set while the device is still busy. It also covers bit 5 set just before the device finishes, and a device that never finishes. A design that trusted bit 5 without the confirming read would report failure in the late-finish case. A design that latched the completing read would export the unsettled low bits. A design with an off-by-one watchdog would poll one time too many or too few, and that shows up as a missing or extra bus access. Data bytes with bit 7 both set and clear catch a comparison that inverts the wrong operand. A stray start in the middle of an operation catches a sequencer that restarts or takes the new address.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSTB,
    ST_WGAP,
    ST_RSTB,
    ST_RSMP
  } st_e;

  typedef enum logic [1:0] {
    RK_POLL,
    RK_CONFIRM,
    RK_FINAL
  } rk_e;

  localparam int unsigned STEP_W     = 3;
  localparam logic [2:0]  STEP_DATA  = 3'd3;
  localparam logic [2:0]  STEP_ABORT = 3'd4;

  localparam logic [11:0] ADDR_KEY_A = 12'hAAA;
  localparam logic [11:0] ADDR_KEY_B = 12'h555;
  localparam logic [7:0]  VAL_KEY_A  = 8'hAA;
  localparam logic [7:0]  VAL_KEY_B  = 8'h55;
  localparam logic [7:0]  VAL_PROG   = 8'hA0;
  localparam logic [7:0]  VAL_ABORT  = 8'hF0;

  localparam int unsigned BIT_DONE = 7;
  localparam int unsigned BIT_ERR  = 5;
endpackage

// File: rtl/fbp_cmd_gen.sv
module fbp_cmd_gen
  import fbp_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [AW-1:0]     tgt_addr_i,
  input  logic [7:0]        tgt_data_i,
  output logic [AW-1:0]     cmd_addr_o,
  output logic [7:0]        cmd_data_o
);
  localparam int unsigned PAD = AW - 12;

  always_comb begin
    unique case (step_i)
      3'd0: begin
        cmd_addr_o = {{PAD{1'b0}}, ADDR_KEY_A};
        cmd_data_o = VAL_KEY_A;
      end
      3'd1: begin
        cmd_addr_o = {{PAD{1'b0}}, ADDR_KEY_B};
        cmd_data_o = VAL_KEY_B;
      end
      3'd2: begin
        cmd_addr_o = {{PAD{1'b0}}, ADDR_KEY_A};
        cmd_data_o = VAL_PROG;
      end
      STEP_DATA: begin
        cmd_addr_o = tgt_addr_i;
        cmd_data_o = tgt_data_i;
      end
      default: begin
        cmd_addr_o = '0;
        cmd_data_o = VAL_ABORT;
      end
    endcase
  end
endmodule

// File: rtl/fbp_status_eval.sv
module fbp_status_eval
  import fbp_pkg::*;
(
  input  logic [7:0] rdata_i,
  input  logic       want_msb_i,
  output logic       match_o,
  output logic       err_o
);
  assign match_o = (rdata_i[BIT_DONE] == want_msb_i);
  // bit 5 only meaningful while bit 7 still mismatches
  assign err_o   = !match_o && rdata_i[BIT_ERR];
endmodule

// File: rtl/fbp_watchdog.sv
module fbp_watchdog #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (run_i && cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= LIM);

  p_wdog_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  p_wdog_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !expired_o || (LIMIT == 0));
endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
  import fbp_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned WDOG_LIMIT = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  output logic          bus_we_o,
  output logic          bus_re_o,
  input  logic [7:0]    bus_rdata_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [7:0]    rdata_o
);
  st_e              st_q;
  rk_e              rk_q;
  logic [STEP_W-1:0] step_q;
  logic [AW-1:0]    tgt_addr_q;
  logic [7:0]       tgt_data_q;
  logic             done_q, fail_q;
  logic [7:0]       rdata_q;

  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          st_match, st_err, wd_expired, wd_clear, wd_run;

  fbp_cmd_gen #(.AW(AW)) u_cmd (
    .step_i     (step_q),
    .tgt_addr_i (tgt_addr_q),
    .tgt_data_i (tgt_data_q),
    .cmd_addr_o (cmd_addr),
    .cmd_data_o (cmd_data)
  );

  fbp_status_eval u_eval (
    .rdata_i    (bus_rdata_i),
    .want_msb_i (tgt_data_q[BIT_DONE]),
    .match_o    (st_match),
    .err_o      (st_err)
  );

  assign wd_clear = (st_q == ST_WGAP) && (step_q == STEP_DATA);
  assign wd_run   = ((st_q == ST_RSTB) || (st_q == ST_RSMP)) && (rk_q == RK_POLL);

  fbp_watchdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (wd_clear),
    .run_i     (wd_run),
    .expired_o (wd_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rk_q       <= RK_POLL;
      step_q     <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          tgt_addr_q <= addr_i;
          tgt_data_q <= data_i;
          step_q     <= '0;
          st_q       <= ST_WSTB;
        end
        ST_WSTB: st_q <= ST_WGAP;
        ST_WGAP: begin
          if (step_q == STEP_ABORT) begin
            done_q <= 1'b1;
            fail_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (step_q == STEP_DATA) begin
            rk_q <= RK_POLL;
            st_q <= ST_RSTB;
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= ST_WSTB;
          end
        end
        ST_RSTB: st_q <= ST_RSMP;
        ST_RSMP: begin
          unique case (rk_q)
            RK_POLL: begin
              if (st_match) begin
                rk_q <= RK_FINAL;
                st_q <= ST_RSTB;
              end else if (st_err) begin
                rk_q <= RK_CONFIRM;
                st_q <= ST_RSTB;
              end else if (wd_expired) begin
                step_q <= STEP_ABORT;
                st_q   <= ST_WSTB;
              end else begin
                st_q <= ST_RSTB;
              end
            end
            RK_CONFIRM: begin
              if (st_match) begin
                rk_q <= RK_FINAL;
                st_q <= ST_RSTB;
              end else begin
                step_q <= STEP_ABORT;
                st_q   <= ST_WSTB;
              end
            end
            default: begin
              rdata_q <= bus_rdata_i;
              done_q  <= 1'b1;
              st_q    <= ST_IDLE;
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_we_o    = (st_q == ST_WSTB);
  assign bus_re_o    = (st_q == ST_RSTB);
  assign bus_addr_o  = bus_re_o ? tgt_addr_q : cmd_addr;
  assign bus_wdata_o = cmd_data;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign rdata_o     = rdata_q;

  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));
  p_strobe_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o || bus_re_o) |=> !(bus_we_o || bus_re_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fail_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);
  p_abort_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> ($past(bus_we_o, 2) && $past(bus_addr_o, 2) == '0
                            && $past(bus_wdata_o, 2) == VAL_ABORT));
  p_final_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> $past(bus_re_o, 2));
  p_hold_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(tgt_addr_q) && $stable(tgt_data_q)));
endmodule

// File: tb/flash_byte_prog_bench.sv
module flash_byte_prog_bench;
  localparam int AW   = 16;
  localparam int WDOG = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_we, bus_re;
  logic [7:0]    bus_rdata = '0;
  logic          done, fail;
  logic [7:0]    rdata;

  always #4 clk = ~clk;

  flash_byte_prog #(.AW(AW), .WDOG_LIMIT(WDOG)) u_flash_byte_prog (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_we_o(bus_we),
    .bus_re_o(bus_re), .bus_rdata_i(bus_rdata), .done_o(done), .fail_o(fail),
    .rdata_o(rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // device model state
  logic [7:0] dev_data = '0;
  int dev_busy = 0;
  int dev_errf = -1;
  int rd_n = 0;
  int rd_base = 0;

  function automatic logic [7:0] devval(int r);
    logic [7:0] v;
    if (r < dev_busy)
      v = {~dev_data[7], r[0], (dev_errf >= 0 && r >= dev_errf), 5'b01010};
    else if (r == dev_busy)
      v = {dev_data[7], ~dev_data[6:0]};
    else
      v = dev_data;
    return v;
  endfunction

  always @(posedge clk) begin
    if (bus_re) begin
      bus_rdata <= devval(rd_n - rd_base);
      rd_n <= rd_n + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: bench timed out, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected access: {we, addr, data}
  logic [AW+8:0] expq[$];
  bit exp_fail;

  task automatic build_expect(input logic [AW-1:0] a, input logic [7:0] d);
    logic [7:0] v;
    logic [7:0] v2;
    int i;
    expq.delete();
    expq.push_back({1'b1, 16'h0AAA, 8'hAA});  // R2
    expq.push_back({1'b1, 16'h0555, 8'h55});  // R2
    expq.push_back({1'b1, 16'h0AAA, 8'hA0});  // R3
    expq.push_back({1'b1, a, d});             // R3
    i = 0;
    forever begin
      expq.push_back({1'b0, a, 8'h00});
      v = devval(i);
      i++;
      if (v[7] == d[7]) begin
        expq.push_back({1'b0, a, 8'h00});
        exp_fail = 1'b0;
        break;
      end
      if (v[5]) begin
        expq.push_back({1'b0, a, 8'h00});
        v2 = devval(i);
        i++;
        if (v2[7] == d[7]) begin
          expq.push_back({1'b0, a, 8'h00});
          exp_fail = 1'b0;
        end else begin
          expq.push_back({1'b1, 16'h0000, 8'hF0});
          exp_fail = 1'b1;
        end
        break;
      end
      if (2 * (i - 1) + 1 >= WDOG) begin
        expq.push_back({1'b1, 16'h0000, 8'hF0});
        exp_fail = 1'b1;
        break;
      end
    end
  endtask

  task automatic run_case(input string req, input logic [AW-1:0] a,
                          input logic [7:0] d, input int busy, input int errf,
                          input bit inject);
    int n;
    bit got;
    logic [AW+8:0] e;
    dev_data = d;
    dev_busy = busy;
    dev_errf = errf;
    rd_base  = rd_n;
    build_expect(a, d);
    n = expq.size();
    got = 1'b0;
    @(negedge clk);
    start = 1'b1; addr = a; data = d;
    @(negedge clk);
    start = 1'b0; addr = ~a; data = ~d;
    for (int c = 0; c < 400; c++) begin
      if (inject && c == 3) begin start = 1'b1; addr = 16'h7777; data = 8'h11; end
      if (inject && c == 4) start = 1'b0;
      chk(!(bus_we && bus_re), "R11", "both strobes", {bus_we, bus_re}, 0);
      if (bus_we || bus_re) begin
        chk(c % 2 == 0, "R11", "strobe slot", c, c & ~1);
        if (expq.size() == 0) begin
          chk(1'b0, req, "unexpected access", {bus_we, bus_addr, bus_wdata}, 0);
        end else begin
          e = expq.pop_front();
          if (e[AW+8])
            chk({bus_we, bus_addr, bus_wdata} == e, req, "write access",
                {bus_we, bus_addr, bus_wdata}, e);
          else
            chk(bus_re && bus_addr == e[AW+7:8], req, "read access (R4)",
                {bus_we, bus_addr}, {1'b0, e[AW+7:8]});
        end
      end
      chk(!fail || done, "R8", "fail without done", fail, done);
      if (done) begin
        got = 1'b1;
        chk(c == 2 * n, "R8", "done cycle", c, 2 * n);
        chk(expq.size() == 0, req, "missing accesses", expq.size(), 0);
        chk(fail == exp_fail, req, "fail flag", fail, exp_fail);
        if (!exp_fail) chk(rdata == d, "R7", "read-back byte", rdata, d);
        @(negedge clk);
        chk(!done, "R8", "done pulse width", done, 0);
        break;
      end
      @(negedge clk);
    end
    chk(got, req, "done seen", got, 1);
  endtask

  initial begin
    #1;
    chk(!bus_we && !bus_re && !done && !fail && rdata == 0, "R1", "reset outputs",
        {bus_we, bus_re, done, fail, rdata}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!bus_we && !bus_re && !done, "R1", "idle after reset", {bus_we, bus_re, done}, 0);
    run_case("R4", 16'h1234, 8'h5A, 3, -1, 1'b0);   // busy a few polls
    run_case("R4", 16'h2040, 8'hC3, 0, -1, 1'b0);   // immediate match, msb set
    run_case("R9", 16'h0F0F, 8'h3C, 4, -1, 1'b1);   // stray start mid-run
    run_case("R6", 16'h4444, 8'h81, 5, 2, 1'b0);    // confirmed error
    run_case("R5", 16'h5555, 8'h12, 3, 2, 1'b0);    // finishes before confirm read
    run_case("R10", 16'h6006, 8'hE7, 100, -1, 1'b0); // never finishes
    run_case("R2", 16'hFFFF, 8'h00, 1, -1, 1'b0);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule